// File: doc/BRIEF.md
# Programmable Routing-Order Sequencer

This block sits beside one output port of a mesh router and decides which input the output arbiter admits next. It is a very small processor: a program memory, a bank of loop-counter registers, a program counter and a mode register. Software fills all of these through a plain write-only register bus. The only outward action is a routing order: the controller presents an input-port number with a valid strobe, then stalls until the arbiter acknowledges that the first flit of the chosen packet has passed.

Counted loops built from a load-immediate, a decrement and a branch-if-nonzero encode long static packet orders compactly. One example is an endless sequence of n packets from one input followed by n packets from another, using a single counter. When the mode register selects round-robin, the sequencer freezes and its valid strobe is masked, so the arbiter falls back to its fair policy.

Top module: `route_order_seq`

## Requirements
- R1: After reset, `ord_val` is low, `prog_mode` is low (round-robin selected) and `halt_err` is low.
- R2: Bus address 0x100 is the mode register; bit 0 drives `prog_mode`. While it is 0 the sequencer executes nothing and `ord_val` stays low. A pending order reappears unchanged when programmed mode returns.
- R3: Instruction format: opcode in [31:29], register select in [26:24], port or branch target in [23:16], immediate in [15:0]. Opcode 2 (WRITE) raises `ord_val` with `ord_port` equal to bits [18:16]. Both stay stable until `ord_ack` is sampled high.
- R4: `ord_val` is low in the cycle after the edge that samples `ord_ack` high with `ord_val` high. Each WRITE yields exactly one order.
- R5: Opcode 1 loads the immediate into the selected register, opcode 3 decrements it by one, and opcode 4 branches to the target when the register is nonzero. Bus addresses 0x108 to 0x10F write registers 0 to 7, and bus addresses 0 to 239 write program words.
- R6: Decrementing a register that holds zero wraps it to 0xFFFF, so a following branch on it is taken.
- R7: Opcode 5 branches unconditionally to the target.
- R8: Reaching a program address above 239, by branch or by running past the end, halts the sequencer and sets `halt_err`. The bit stays set until reset, and no order is issued while halted.
- R9: A bus write to address 0x101 sets the program counter and restarts execution there. It drops any pending order and also resumes a halted sequencer.
- R10: Opcode 0 and the unused opcodes 6 and 7 only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register-bus write strobe |
| bus_addr | input | 9 | Register-bus word address |
| bus_wdata | input | 32 | Register-bus write data |
| ord_ack | input | 1 | Arbiter acknowledge of the current order |
| ord_port | output | 3 | Input port selected by the current order |
| ord_val | output | 1 | Current order is valid |
| prog_mode | output | 1 | 1 selects programmed arbitration, 0 round-robin |
| halt_err | output | 1 | Sticky error: program counter left the program |

## Verification
A corrupted counter or program counter shows up as a wrong port in the order stream. The bench predicts that stream packet by packet, so the fault appears at the first order after the loop boundary that went wrong. A broken handshake shows within one cycle of an acknowledge, as a strobe that lingers or a port that changes while waiting. Wrap-around, halting and restart each steer the next order to a distinct port, so a fault in any of them is visible on the first order that follows.

// File: rtl/route_order_pkg.sv
package route_order_pkg;
   localparam int INSTR_W = 32;
   localparam int OP_W    = 3;
   localparam int RSEL_W  = 3;
   localparam int TGT_W   = 8;
   localparam int IMM_W   = 16;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 3'd0,
      OP_LDI  = 3'd1,
      OP_WR   = 3'd2,
      OP_DEC  = 3'd3,
      OP_BNZ  = 3'd4,
      OP_JMP  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } opcode_e;

   typedef struct packed {
      opcode_e            op;
      logic [1:0]         spare;
      logic [RSEL_W-1:0]  rsel;
      logic [TGT_W-1:0]   field;
      logic [IMM_W-1:0]   imm;
   } instr_t;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_WAIT = 2'd1,
      ST_HALT = 2'd2
   } seq_state_e;
endpackage

// File: rtl/route_order_imem.sv
module route_order_imem #(
   parameter int DEPTH  = 240,
   parameter int WIDTH  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
   end

   // Out-of-range fetches read as zero; the core halts on them anyway.
   always_comb begin
      if (int'(raddr) < DEPTH) rdata = mem[raddr];
      else                     rdata = '0;
   end
endmodule

// File: rtl/route_order_regs.sv
module route_order_regs #(
   parameter int NREG  = 8,
   parameter int REG_W = 16,
   localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ex_we,
   input  logic [SEL_W-1:0] ex_sel,
   input  logic [REG_W-1:0] ex_data,
   input  logic             bus_we,
   input  logic [SEL_W-1:0] bus_sel,
   input  logic [REG_W-1:0] bus_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [REG_W-1:0] rd_data
);
   logic [REG_W-1:0] regs_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      // Bus writes win over the executing instruction.
      always_ff @(posedge clk) begin
         if (!rst_n)                                    regs_q[g] <= '0;
         else if (bus_we && (int'(bus_sel) == g))       regs_q[g] <= bus_data;
         else if (ex_we && (int'(ex_sel) == g))         regs_q[g] <= ex_data;
      end
   end

   assign rd_data = regs_q[rd_sel];
endmodule

// File: rtl/route_order_seq.sv
module route_order_seq
   import route_order_pkg::*;
#(
   parameter int NREG       = 8,
   parameter int REG_W      = 16,
   parameter int PROG_DEPTH = 240,
   parameter int PORT_W     = 3,
   parameter int BUS_AW     = 9,
   parameter int MODE_ADDR  = 'h100,
   parameter int PC_ADDR    = 'h101,
   parameter int REG_BASE   = 'h108
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              ord_ack,
   output logic [PORT_W-1:0] ord_port,
   output logic              ord_val,
   output logic              prog_mode,
   output logic              halt_err
);
   localparam int PC_W  = TGT_W;
   localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

   if (PROG_DEPTH < 1 || PROG_DEPTH > (1 << PC_W) - 1) begin : g_bad_depth
      $error("PROG_DEPTH must leave one out-of-range PC value");
   end
   if (NREG < 1 || SEL_W > RSEL_W) begin : g_bad_nreg
      $error("NREG must fit the register-select field");
   end
   if (REG_W < 1 || REG_W > IMM_W) begin : g_bad_regw
      $error("REG_W must not exceed the immediate field");
   end
   if (PORT_W < 1 || PORT_W > TGT_W) begin : g_bad_portw
      $error("PORT_W must fit the port field");
   end
   if (REG_BASE + NREG > (1 << BUS_AW) || PROG_DEPTH > MODE_ADDR) begin : g_bad_map
      $error("bus map does not fit");
   end

   // ---------------- bus decode ----------------
   logic mode_wr, pc_wr, reg_wr, mem_wr;
   assign mode_wr = bus_we && (int'(bus_addr) == MODE_ADDR);
   assign pc_wr   = bus_we && (int'(bus_addr) == PC_ADDR);
   assign reg_wr  = bus_we && (int'(bus_addr) >= REG_BASE) && (int'(bus_addr) < REG_BASE + NREG);
   assign mem_wr  = bus_we && (int'(bus_addr) < PROG_DEPTH);

   logic [BUS_AW-1:0] reg_off;
   assign reg_off = bus_addr - BUS_AW'(REG_BASE);

   // ---------------- state ----------------
   seq_state_e        state_q;
   logic [PC_W-1:0]   pc_q;
   logic              mode_q;
   logic              val_q;
   logic [PORT_W-1:0] port_q;
   logic              err_q;

   // ---------------- fetch and decode ----------------
   logic [INSTR_W-1:0] fetch_word;
   instr_t             ins;

   route_order_imem #(
      .DEPTH (PROG_DEPTH),
      .WIDTH (INSTR_W),
      .ADDR_W(PC_W)
   ) u_imem (
      .clk  (clk),
      .we   (mem_wr),
      .waddr(bus_addr[PC_W-1:0]),
      .wdata(bus_wdata),
      .raddr(pc_q),
      .rdata(fetch_word)
   );

   assign ins = instr_t'(fetch_word);

   logic             in_range;
   logic             step;
   logic [REG_W-1:0] reg_rd;
   logic             ex_we;
   logic [REG_W-1:0] ex_data;

   assign in_range = int'(pc_q) < PROG_DEPTH;
   assign step     = mode_q && (state_q == ST_RUN) && !pc_wr;

   route_order_regs #(
      .NREG (NREG),
      .REG_W(REG_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ex_we   (ex_we),
      .ex_sel  (ins.rsel[SEL_W-1:0]),
      .ex_data (ex_data),
      .bus_we  (reg_wr),
      .bus_sel (reg_off[SEL_W-1:0]),
      .bus_data(bus_wdata[REG_W-1:0]),
      .rd_sel  (ins.rsel[SEL_W-1:0]),
      .rd_data (reg_rd)
   );

   always_comb begin
      ex_we   = 1'b0;
      ex_data = reg_rd;
      if (step && in_range) begin
         if (ins.op == OP_LDI) begin
            ex_we   = 1'b1;
            ex_data = ins.imm[REG_W-1:0];
         end else if (ins.op == OP_DEC) begin
            ex_we   = 1'b1;
            ex_data = reg_rd - REG_W'(1);
         end
      end
   end

   // Next program counter for the instruction being executed.
   logic [PC_W-1:0] pc_seq, pc_next;
   assign pc_seq = pc_q + PC_W'(1);

   always_comb begin
      case (ins.op)
         OP_JMP:  pc_next = ins.field;
         OP_BNZ:  pc_next = (reg_rd != '0) ? ins.field : pc_seq;
         default: pc_next = pc_seq;
      endcase
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         pc_q    <= '0;
         mode_q  <= 1'b0;
         val_q   <= 1'b0;
         port_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         if (mode_wr) mode_q <= bus_wdata[0];
         if (pc_wr) begin
            pc_q    <= bus_wdata[PC_W-1:0];
            state_q <= ST_RUN;
            val_q   <= 1'b0;
         end else if (mode_q) begin
            case (state_q)
               ST_RUN: begin
                  if (!in_range) begin
                     state_q <= ST_HALT;
                     err_q   <= 1'b1;
                  end else begin
                     pc_q <= pc_next;
                     if (ins.op == OP_WR) begin
                        port_q  <= ins.field[PORT_W-1:0];
                        val_q   <= 1'b1;
                        state_q <= ST_WAIT;
                     end
                  end
               end
               ST_WAIT: begin
                  if (ord_ack) begin
                     val_q   <= 1'b0;
                     state_q <= ST_RUN;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ord_port  = port_q;
   assign ord_val   = val_q && mode_q;
   assign prog_mode = mode_q;
   assign halt_err  = err_q;
endmodule

// File: rtl/route_order_seq_chk.sv
module route_order_seq_chk #(
   parameter int BUS_AW    = 9,
   parameter int PORT_W    = 3,
   parameter int MODE_ADDR = 'h100,
   parameter int PC_ADDR   = 'h101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              ord_ack,
   input logic [PORT_W-1:0] ord_port,
   input logic              ord_val,
   input logic              prog_mode,
   input logic              halt_err
);
   logic ctl_wr;
   assign ctl_wr = bus_we && ((int'(bus_addr) == MODE_ADDR) || (int'(bus_addr) == PC_ADDR));

   // R3: a waiting order holds its port until acknowledged
   a_r3_hold_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_val && !ord_ack && !ctl_wr) |=> (ord_val && $stable(ord_port)));

   // R4: acknowledge retires the order for at least one cycle
   a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_val && ord_ack) |=> !ord_val);

   // R2: no order is offered in round-robin mode
   a_r2_rr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_mode |-> !ord_val);

   // R8: the error flag never clears on its own
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt_err |=> halt_err);

   // R9: a program-counter write drops the pending order
   a_r9_pc_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (int'(bus_addr) == PC_ADDR)) |=> !ord_val);
endmodule

bind route_order_seq route_order_seq_chk #(
   .BUS_AW   (BUS_AW),
   .PORT_W   (PORT_W),
   .MODE_ADDR(MODE_ADDR),
   .PC_ADDR  (PC_ADDR)
) u_chk (.*);

// File: tb/route_order_seq_test.sv
module route_order_seq_test;
   localparam int A_MODE = 'h100;
   localparam int A_PC   = 'h101;
   localparam int A_REG  = 'h108;
   localparam int P_L    = 4;
   localparam int P_W    = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        ord_ack = 1'b0;
   logic [2:0]  ord_port;
   logic        ord_val;
   logic        prog_mode;
   logic        halt_err;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   route_order_seq uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ord_ack(ord_ack), .ord_port(ord_port),
      .ord_val(ord_val), .prog_mode(prog_mode), .halt_err(halt_err)
   );

   function automatic logic [31:0] enc(int op, int r, int f, int imm);
      return {op[2:0], 2'b00, r[2:0], f[7:0], imm[15:0]};
   endfunction

   // expected port of the k-th order of the n/n loop
   function automatic int exp_lw(int k, int n);
      return ((k % (2 * n)) < n) ? P_L : P_W;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic bw(int addr, logic [31:0] data);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = addr[8:0]; bus_wdata = data;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic wait_val(output int p, output bit ok, input int lim);
      ok = 0; p = -1;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (ord_val) begin ok = 1; p = ord_port; break; end
      end
   endtask

   // acknowledge after a random delay; checks hold (R3) and drop (R4)
   task automatic ack_order(input int p, input string req);
      int d = $urandom % 4;
      bit held = 1;
      for (int i = 0; i < d; i++) begin
         @(negedge clk);
         if (!ord_val || ord_port != p[2:0]) held = 0;
      end
      if (d > 0) chk(held, "R3", "order held while waiting", ord_port, p);
      ord_ack = 1'b1;
      @(negedge clk);
      ord_ack = 1'b0;
      chk(!ord_val, "R4", {"valid low after ack ", req}, ord_val, 0);
   endtask

   task automatic take(input int exp, input string req, input string what);
      int p; bit ok;
      wait_val(p, ok, 50);
      chk(ok && p == exp, req, what, p, exp);
      if (ok) ack_order(p, req);
   endtask

   task automatic start_at0();
      bw(A_PC, 0);
      bw(A_MODE, 1);
   endtask

   initial begin
      int n;
      int p;
      bit ok;
      void'($urandom(32'd20240));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ord_val, "R1", "reset valid", ord_val, 0);
      chk(!prog_mode, "R1", "reset mode", prog_mode, 0);
      chk(!halt_err, "R1", "reset error", halt_err, 0);

      // R5 R7: n from Local then n from West, forever
      n = 2 + $urandom % 4;
      bw(0, enc(1, 0, 0, n));
      bw(1, enc(2, 0, P_L, 0));
      bw(2, enc(3, 0, 0, 0));
      bw(3, enc(4, 0, 1, 0));
      bw(4, enc(1, 0, 0, n));
      bw(5, enc(2, 0, P_W, 0));
      bw(6, enc(3, 0, 0, 0));
      bw(7, enc(4, 0, 5, 0));
      bw(8, enc(5, 0, 0, 0));
      repeat (4) @(negedge clk);
      chk(!ord_val, "R2", "no order before programmed mode", ord_val, 0);
      bw(A_MODE, 1);
      chk(prog_mode, "R2", "mode bit", prog_mode, 1);
      for (int k = 0; k < 4 * n; k++) take(exp_lw(k, n), "R5", "loop order (R7 wrap-around)");

      // R2: leaving programmed mode hides the pending order
      wait_val(p, ok, 50);
      bw(A_MODE, 0);
      repeat (3) @(negedge clk);
      chk(!ord_val, "R2", "valid masked in round-robin", ord_val, 0);
      bw(A_MODE, 1);
      chk(ord_val && ord_port == P_L, "R2", "pending order resumes", ord_port, P_L);

      // R5: counter loaded over the bus
      bw(A_MODE, 0);
      bw(A_REG + 3, 2);
      bw(0, enc(2, 0, 5, 0));
      bw(1, enc(3, 3, 0, 0));
      bw(2, enc(4, 3, 0, 0));
      bw(3, enc(2, 0, 1, 0));
      bw(4, enc(5, 0, 4, 0));
      start_at0();
      take(5, "R5", "bus-loaded count first");
      take(5, "R5", "bus-loaded count second");
      take(1, "R5", "exit after count");

      // R6: decrement from zero wraps, branch taken
      bw(A_MODE, 0);
      bw(0, enc(1, 2, 0, 0));
      bw(1, enc(3, 2, 0, 0));
      bw(2, enc(4, 2, 5, 0));
      bw(3, enc(2, 0, 1, 0));
      bw(4, enc(5, 0, 4, 0));
      bw(5, enc(2, 0, 6, 0));
      bw(6, enc(5, 0, 6, 0));
      start_at0();
      take(6, "R6", "wrapped counter takes branch");

      // R10: NOP and unused opcodes advance
      bw(A_MODE, 0);
      bw(0, enc(0, 0, 7, 0));
      bw(1, enc(7, 0, 7, 0));
      bw(2, enc(6, 1, 7, 9));
      bw(3, enc(2, 0, 2, 0));
      bw(4, enc(5, 0, 4, 0));
      start_at0();
      take(2, "R10", "skip to first WRITE");

      // R9: PC write aborts a pending order
      bw(A_MODE, 0);
      bw(0, enc(2, 0, 1, 0));
      bw(10, enc(2, 0, 7, 0));
      bw(11, enc(5, 0, 11, 0));
      start_at0();
      wait_val(p, ok, 20);
      chk(ok && p == 1, "R9", "order before restart", p, 1);
      bw(A_PC, 10);
      take(7, "R9", "order from restart address");

      // R8: branch out of the program halts with sticky error
      bw(A_MODE, 0);
      bw(0, enc(5, 0, 250, 0));
      start_at0();
      repeat (4) @(negedge clk);
      chk(halt_err, "R8", "error set", halt_err, 1);
      wait_val(p, ok, 10);
      chk(!ok, "R8", "no order while halted", p, -1);
      bw(0, enc(2, 0, 5, 0));
      bw(1, enc(5, 0, 1, 0));
      bw(A_PC, 0);
      take(5, "R8", "restart after halt (R9)");
      chk(halt_err, "R8", "error still set", halt_err, 1);

      // R8: running past the last word halts too
      bw(A_MODE, 0);
      bw(239, enc(0, 0, 0, 0));
      bw(A_PC, 239);
      bw(A_MODE, 1);
      wait_val(p, ok, 8);
      chk(!ok, "R8", "no order after running off the end", p, -1);

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule